// File: doc/BRIEF.md
# Seven-Slot Multi-Lane Deserializer

This block turns several serial lanes back into one wide parallel word. Each lane carries seven bits in every period of a slower forwarded frame clock. A bit clock at seven times the frame rate, phase aligned with the frame clock, runs all of the logic. The frame clock is sampled as data in the bit-clock domain. Its rising edge marks slot 0 of a new frame. The seven bits of each lane are placed into the output word at index `lane*7 + slot`. Four lanes give 28 bits and three lanes give 21 bits, chosen by the `LANES` parameter.

A captured word passes through one staging register and one output register, each loaded on a frame edge, so it reaches the outputs two frame periods after its first bit was sampled. The output strobe is low when the word changes. It rises at the middle of the frame, so its rising edge has data held stable on both sides of it.

A small controller with four states owns the output side:
- `ST_OFF`: power-down. Entered from any state while `pd_n` is low. Leaves to `ST_FILL` once `pd_n` is high.
- `ST_FILL`: waiting for a complete frame to reach the output register. Leaves to `ST_RUN` on that load, or to `ST_LOST` if the frame clock goes quiet.
- `ST_RUN`: streaming with the strobe active. Leaves to `ST_LOST` on frame-clock loss.
- `ST_LOST`: frame clock lost. Returns to `ST_FILL` on the next frame edge.

Reset enters `ST_FILL`.

Top module: `serial7_deser`

## Requirements
- R1: A frame-clock rising edge, seen as `frame_clk` high in a bit-clock cycle after a low one, makes that cycle slot 0. The following six cycles are slots 1 to 6. The bit of lane `l` in slot `s` lands in output bit `l*7+s`.
- R2: A word captured in frame k appears on `word_out` right after the bit-clock edge that detects the frame-k+2 edge. That is 14 bit clocks after its slot-0 sample.
- R3: While streaming, `strobe_out` is low when `word_out` changes and rises exactly 3 bit clocks later. It stays high for 4 bit clocks and low for 3, giving a period of 7 bit clocks. `word_out` does not change while the strobe is high.
- R4: While `pd_n` is low, `word_out` is all zeros and `strobe_out` is low, with no clock delay. After `pd_n` returns high, the strobe stays low until a frame has passed through the pipeline.
- R5: During and right after reset, `word_out` is zero and `strobe_out` is low.
- R6: With every lane held high and the frame clock running, every bit of `word_out` becomes 1.
- R7: If no frame edge appears for more than 14 bit clocks (2 frame periods), `strobe_out` is held low and `word_out` keeps its last word. After the frame clock resumes, the strobe returns with the word of the first new frame.
- R8: With `LANES` set to 3, the block delivers a 21-bit word with the same mapping and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Forwarded frame clock, sampled as data |
| lane_in | input | LANES | Serial data lanes, one bit per bit clock |
| pd_n | input | 1 | Active-low power-down |
| word_out | output | LANES*7 | Reassembled parallel word |
| strobe_out | output | 1 | Rising edge marks valid `word_out` |

## Verification
The hardest condition to reach is a loss of the frame clock that starts exactly at a frame boundary while words are in flight. The recovery must discard the stale staged word and output only the frame captured at the first edge after the gap. The bench stops driving frame edges for 25 bit clocks between two complete frames. It checks that the held word and the low strobe persist past the 14-clock threshold, then checks that the next strobe carries the first post-gap frame. Power-down is applied in the middle of a frame, so a partly captured frame straddles the release.

// File: rtl/serial7_pkg.sv
package serial7_pkg;

    // Bit slots carried by each lane in one frame.
    localparam int SLOTS_DEF = 7;

    // Controller states on the output side.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2,
        ST_LOST = 2'd3
    } link_state_e;

endpackage

// File: rtl/serial7_frame_track.sv
module serial7_frame_track #(
    parameter int SLOTS      = 7,
    parameter int LOST_LIMIT = 14,
    localparam int SW        = $clog2(SLOTS + 1),
    localparam int GW        = $clog2(LOST_LIMIT + 2)
) (
    input  logic          clk_bit,
    input  logic          rst_n,
    input  logic          frame_clk,
    output logic          frame_edge,
    output logic [SW-1:0] slot_idx,
    output logic [SW-1:0] slot_cur,
    output logic [GW-1:0] gap_cnt,
    output logic          frame_full,
    output logic          link_lost
);

    localparam logic [SW-1:0] IDLE_SLOT = SW'(SLOTS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [GW-1:0] GAP_TOP   = GW'(LOST_LIMIT + 1);

    logic          fclk_q;
    logic [SW-1:0] slot_q;
    logic [GW-1:0] gap_q;
    logic          full_q;

    assign frame_edge = frame_clk & ~fclk_q;
    assign slot_idx   = frame_edge ? '0 : slot_q;

    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            fclk_q <= 1'b1;
            slot_q <= IDLE_SLOT;
            gap_q  <= '0;
            full_q <= 1'b0;
        end else begin
            fclk_q <= frame_clk;
            if (slot_idx != IDLE_SLOT) begin
                slot_q <= slot_idx + SW'(1);
            end
            if (frame_edge) begin
                gap_q <= '0;
            end else if (gap_q != GAP_TOP) begin
                gap_q <= gap_q + GW'(1);
            end
            if (slot_idx == LAST_SLOT) begin
                full_q <= 1'b1;
            end else if (frame_edge) begin
                full_q <= 1'b0;
            end
        end
    end

    assign slot_cur   = slot_q;
    assign gap_cnt    = gap_q;
    assign frame_full = full_q;
    assign link_lost  = (gap_q == GAP_TOP);

endmodule

// File: rtl/serial7_lane_capture.sv
module serial7_lane_capture #(
    parameter int LANES = 4,
    parameter int SLOTS = 7,
    localparam int SW   = $clog2(SLOTS + 1),
    localparam int W    = LANES * SLOTS
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_in,
    input  logic [SW-1:0]    slot_idx,
    output logic [W-1:0]     asm_word
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] bank;

        always_ff @(posedge clk_bit) begin
            if (!rst_n) begin
                bank <= '0;
            end else begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (slot_idx == SW'(s)) begin
                        bank[s] <= lane_in[l];
                    end
                end
            end
        end

        assign asm_word[l*SLOTS +: SLOTS] = bank;
    end

endmodule

// File: rtl/serial7_word_pipe.sv
module serial7_word_pipe #(
    parameter int W = 28
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         frame_edge,
    input  logic         frame_full,
    input  logic         flush,
    input  logic         clear_out,
    input  logic [W-1:0] asm_word,
    output logic [W-1:0] word_q,
    output logic         load
);

    logic         stage_v;
    logic [W-1:0] stage_w;
    logic [W-1:0] out_w;

    assign load = frame_edge & stage_v & ~flush;

    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            stage_v <= 1'b0;
            stage_w <= '0;
            out_w   <= '0;
        end else begin
            if (flush) begin
                stage_v <= 1'b0;
            end else if (frame_edge) begin
                stage_v <= frame_full;
                stage_w <= asm_word;
            end
            if (clear_out) begin
                out_w <= '0;
            end else if (load) begin
                out_w <= stage_w;
            end
        end
    end

    assign word_q = out_w;

endmodule

// File: rtl/serial7_deser.sv
module serial7_deser
    import serial7_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SLOTS      = SLOTS_DEF,
    parameter int LOST_LIMIT = 2 * SLOTS,
    localparam int W         = LANES * SLOTS,
    localparam int SW        = $clog2(SLOTS + 1),
    localparam int GW        = $clog2(LOST_LIMIT + 2),
    localparam int HALF      = SLOTS / 2
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             frame_clk,
    input  logic [LANES-1:0] lane_in,
    input  logic             pd_n,
    output logic [W-1:0]     word_out,
    output logic             strobe_out
);

    logic          frame_edge;
    logic [SW-1:0] slot_idx;
    logic [SW-1:0] slot_cur;
    logic [GW-1:0] gap_cnt;
    logic          frame_full;
    logic          link_lost;
    logic [W-1:0]  asm_word;
    logic [W-1:0]  word_q;
    logic          load;
    logic          flush;
    logic          clear_out;
    logic          strobe_raw;

    link_state_e state_q, state_d;

    serial7_frame_track #(
        .SLOTS      (SLOTS),
        .LOST_LIMIT (LOST_LIMIT)
    ) track_i (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .frame_edge (frame_edge),
        .slot_idx   (slot_idx),
        .slot_cur   (slot_cur),
        .gap_cnt    (gap_cnt),
        .frame_full (frame_full),
        .link_lost  (link_lost)
    );

    serial7_lane_capture #(
        .LANES (LANES),
        .SLOTS (SLOTS)
    ) cap_i (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .lane_in  (lane_in),
        .slot_idx (slot_idx),
        .asm_word (asm_word)
    );

    serial7_word_pipe #(
        .W (W)
    ) pipe_i (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .frame_edge (frame_edge),
        .frame_full (frame_full),
        .flush      (flush),
        .clear_out  (clear_out),
        .asm_word   (asm_word),
        .word_q     (word_q),
        .load       (load)
    );

    // State register.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!pd_n) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_FILL;
                ST_FILL: begin
                    if (link_lost)  state_d = ST_LOST;
                    else if (load)  state_d = ST_RUN;
                end
                ST_RUN:  begin
                    if (link_lost)  state_d = ST_LOST;
                end
                ST_LOST: begin
                    if (frame_edge) state_d = ST_FILL;
                end
                default: state_d = ST_FILL;
            endcase
        end
    end

    // Outputs of the controller.
    always_comb begin
        flush      = ~pd_n;
        clear_out  = ~pd_n;
        strobe_raw = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                flush     = 1'b1;
                clear_out = 1'b1;
            end
            ST_FILL: ;
            ST_RUN: begin
                strobe_raw = (slot_cur > SW'(HALF)) && (gap_cnt < GW'(SLOTS));
            end
            ST_LOST: begin
                flush = 1'b1;
            end
            default: ;
        endcase
    end

    assign word_out   = pd_n ? word_q : '0;
    assign strobe_out = pd_n & strobe_raw;

endmodule

// File: rtl/serial7_chk.sv
module serial7_chk #(
    parameter int SLOTS      = 7,
    parameter int LOST_LIMIT = 14,
    parameter int W          = 28,
    localparam int HIGH_LEN  = SLOTS - SLOTS / 2
) (
    input logic         clk_bit,
    input logic         rst_n,
    input logic         frame_clk,
    input logic         pd_n,
    input logic         strobe_out,
    input logic [W-1:0] word_out
);

    logic       fq;
    logic [7:0] own_gap;
    logic [1:0] edges;
    logic [7:0] hi_len;
    logic       edge_seen;

    assign edge_seen = frame_clk & ~fq;

    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            fq      <= 1'b1;
            own_gap <= '0;
            edges   <= '0;
            hi_len  <= '0;
        end else begin
            fq <= frame_clk;
            if (edge_seen)            own_gap <= '0;
            else if (own_gap != 8'hFF) own_gap <= own_gap + 8'd1;
            if (!pd_n)                                  edges <= '0;
            else if (edge_seen && edges != 2'd3)        edges <= edges + 2'd1;
            else if (!edge_seen && own_gap > 8'(LOST_LIMIT)) edges <= '0;
            hi_len <= strobe_out ? hi_len + 8'd1 : 8'd0;
        end
    end

    // R4: no strobe before a frame has gone through after wake or reset.
    assert_fill_R4: assert property (@(posedge clk_bit) disable iff (!rst_n)
        strobe_out |-> edges >= 2'd2);

    // R4: the first cycle after power-down release shows a cleared word.
    assert_wake_R4: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(pd_n) |-> (!strobe_out && word_out == '0));

    // R3: word stable while the strobe is high.
    assert_hold_R3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (strobe_out && $past(strobe_out)) |-> $stable(word_out));

    // R3: strobe high time bounded by the high half of the frame.
    assert_width_R3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        strobe_out |-> hi_len < 8'(HIGH_LEN));

    // R7: lost frame clock keeps strobe low and word held.
    assert_lost_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (own_gap > 8'(LOST_LIMIT) && pd_n && $past(pd_n)) |-> (!strobe_out && $stable(word_out)));

endmodule

bind serial7_deser serial7_chk #(
    .SLOTS      (SLOTS),
    .LOST_LIMIT (LOST_LIMIT),
    .W          (W)
) chk_i (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .frame_clk  (frame_clk),
    .pd_n       (pd_n),
    .strobe_out (strobe_out),
    .word_out   (word_out)
);

// File: tb/serial7_deser_tb_top.sv
module serial7_deser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_clk = 1'b0;
    logic [3:0]  lane_in = '0;
    logic        pd_n = 1'b1;
    logic [27:0] word_out;
    logic        strobe_out;
    logic [20:0] word3;
    logic        strobe3;

    always #10 clk = ~clk;

    serial7_deser dut_i (
        .clk_bit    (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .lane_in    (lane_in),
        .pd_n       (pd_n),
        .word_out   (word_out),
        .strobe_out (strobe_out)
    );

    serial7_deser #(.LANES(3)) dut3_i (
        .clk_bit    (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .lane_in    (lane_in[2:0]),
        .pd_n       (pd_n),
        .word_out   (word3),
        .strobe_out (strobe3)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cur    = -1;
    int phase  = 0;
    bit run_clk = 1'b1;
    int pat_mode = 0;
    int dir_idx = 0;
    logic [27:0] sent [0:255];
    bit          ones_hist [0:255];
    logic [27:0] prev_w = '0;
    logic        prev_s = 1'b0;
    logic        prev_s3 = 1'b0;
    int last_chg = -100;
    int last_rise = -100;
    int hi_cnt = 0;
    int wake_cnt = 0;
    int stop_cnt = 0;
    logic [27:0] w_stop = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [27:0] make_word(input int mode, input int idx);
        logic [27:0] v;
        if (mode == 1)      v = 28'd1 << idx;
        else if (mode == 2) v = '1;
        else                v = 28'($urandom);
        return v;
    endfunction

    task automatic step();
        logic        s;
        logic [27:0] w;
        logic [27:0] exp;
        @(negedge clk);
        cyc++;
        s = strobe_out;
        w = word_out;
        if (!rst_n) begin
            check(w == '0 && !s, "R5 reset state", w, '0);
        end else begin
            if (w != prev_w) last_chg = cyc;
            if (wake_cnt > 0 && wake_cnt <= 7)
                check(!s, "R4 R5 strobe low before first frame", {27'd0, s}, '0);
            if (!pd_n)
                check(w == '0 && !s, "R4 power-down outputs", w, '0);
            if (!run_clk) begin
                stop_cnt++;
                if (stop_cnt == 2) w_stop = w;
                if (stop_cnt >= 17)
                    check(!s && w == w_stop, "R7 lost clock holds word, strobe low", w, w_stop);
            end
            if (s && !prev_s && cur >= 2) begin
                exp = sent[(cur - 2) & 255];
                check(w == exp, "R1 R2 word after two frames", w, exp);
                if (ones_hist[(cur - 2) & 255])
                    check(w == '1, "R6 all lanes high", w, '1);
                if (cyc - last_chg <= 7)
                    check(cyc - last_chg == 3, "R3 strobe rises 3 clocks after change",
                          28'(cyc - last_chg), 28'd3);
                if (cyc - last_rise <= 10)
                    check(cyc - last_rise == 7, "R3 strobe period",
                          28'(cyc - last_rise), 28'd7);
                last_rise = cyc;
            end
            if (!s && prev_s && pd_n)
                check(hi_cnt == 4, "R3 strobe high width", 28'(hi_cnt), 28'd4);
            hi_cnt = s ? hi_cnt + 1 : 0;
            if (strobe3 && !prev_s3 && cur >= 2)
                check(word3 == sent[(cur - 2) & 255][20:0], "R8 three-lane word",
                      {7'd0, word3}, {7'd0, sent[(cur - 2) & 255][20:0]});
            if (wake_cnt > 0) wake_cnt++;
        end
        prev_w  = w;
        prev_s  = s;
        prev_s3 = strobe3;
        // drive next cycle
        if (run_clk) begin
            if (phase == 0) begin
                cur++;
                sent[cur & 255]      = make_word(pat_mode, dir_idx);
                ones_hist[cur & 255] = (pat_mode == 2);
            end
            frame_clk = (phase < 4);
            for (int l = 0; l < 4; l++) lane_in[l] = sent[cur & 255][l*7 + phase];
            phase = (phase == 6) ? 0 : phase + 1;
        end else begin
            frame_clk = 1'b0;
            lane_in   = 4'($urandom);
        end
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n * 7; i++) step();
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) begin
            sent[i] = '0;
            ones_hist[i] = 1'b0;
        end
        for (int i = 0; i < 6; i++) step();
        @(negedge clk);
        rst_n = 1'b1;
        wake_cnt = 1;
        run_frames(30);
        // R1: single-bit placement frames
        pat_mode = 1;
        foreach (sent[k]) if (k < 4) begin
            dir_idx = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 19 : 27;
            run_frames(1);
        end
        pat_mode = 0;
        run_frames(3);
        // R6: all lanes high
        pat_mode = 2;
        run_frames(4);
        pat_mode = 0;
        run_frames(3);
        // R4: power-down in mid-frame
        for (int i = 0; i < 3; i++) step();
        pd_n = 1'b0;
        for (int i = 0; i < 19; i++) step();
        pd_n = 1'b1;
        wake_cnt = 1;
        for (int i = 0; i < 24; i++) step();
        run_frames(6);
        // R7: frame clock stops at a frame boundary
        while (phase != 0) step();
        run_clk = 1'b0;
        stop_cnt = 0;
        for (int i = 0; i < 25; i++) step();
        run_clk = 1'b1;
        run_frames(10);
        run_frames(60);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule